// File: doc/BRIEF.md
# Locked-Access Address and Lane Unit

This unit sits between an integer pipeline and a plain memory port. For every memory operation it takes a base register value and a signed 16-bit displacement. It adds them into an effective address and checks that address against the natural alignment of the access. It then issues a request to the aligned quadword that contains the address, with an 8-bit byte-lane mask and the store data shifted onto those lanes.

The unit also holds the reservation used by load-locked / store-conditional pairs. A load-locked sets a lock flag and records the quadword it touched. A conditional store goes to memory only while the flag is set. It returns the old flag value as a one-bit result and always clears the flag. An ordinary store that lands on the reserved quadword also clears the flag. A faulting access touches neither memory nor the reservation.

All outputs are registered. Results appear one clock after the operation is presented.

Top module: `mem_lock_unit`

## Requirements
- R1: The effective address is baseVal plus the sign-extended 16-bit disp, modulo 2^64. memAddr carries it with bits 2:0 cleared. Operation codes on opCode: 0 load byte, 1 load word, 2 load longword, 3 load quadword, 4 load-locked longword, 5 load-locked quadword, 6 load unaligned quadword, 8 store byte, 9 store word, 10 store longword, 11 store quadword, 12 conditional store longword, 13 conditional store quadword, 14 store unaligned quadword.
- R2: A word access at an odd address, a longword access (plain, locked or conditional) at an address that is not a multiple of 4, and a quadword access at an address that is not a multiple of 8 raise alignFault for one cycle. Such an access issues no request and no write.
- R3: memByteEn has 1, 2, 4 or 8 consecutive ones for byte, word, longword or quadword size, starting at lane addr[2:0]. memWData is the low bytes of storeData shifted up by 8*addr[2:0] on writes, and zero otherwise.
- R4: An unaligned-quadword access (codes 6 and 14) never faults. It uses lane mask 0xFF and unshifted data, whatever the value of addr[2:0].
- R5: A non-faulting load-locked sets the lock flag and records the quadword address as the reservation.
- R6: A non-faulting conditional store writes memory only if the lock flag is set. One cycle later it raises scResultValid with scResult equal to the old flag (bit 0, upper bits zero), and the flag is cleared.
- R7: A non-faulting ordinary store whose quadword address equals the reservation clears the lock flag. A store to any other quadword leaves the flag unchanged.
- R8: A faulting access, including a faulting load-locked or conditional store, leaves the lock flag and the reservation unchanged.
- R9: With opValid low, or with opCode 7 or 15, the next cycle shows memReq, memWrite, alignFault and scResultValid low, and memAddr, memByteEn and memWData zero.
- R10: During reset all outputs are zero and the lock flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation code (see R1) |
| baseVal | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| storeData | input | 64 | Source register value for stores |
| memReq | output | 1 | Memory request issued |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 64 | Quadword-aligned request address |
| memByteEn | output | 8 | Byte-lane mask within the quadword |
| memWData | output | 64 | Lane-aligned write data |
| alignFault | output | 1 | Alignment fault pulse |
| scResultValid | output | 1 | Conditional-store result present |
| scResult | output | 64 | Old lock flag returned by a conditional store |

## Verification
Every port result lies one register stage behind its operation: request, lanes, data, fault and conditional-store result all appear on the first rising edge after the operation is driven. The bench drives each operation on a falling edge and samples 1 ns after the following rising edge. The lock flag cannot be seen directly. It shows up in the result of the next conditional store, so each reservation scenario is checked one operation later through that result.

// File: rtl/mem_lock_pkg.sv
package mem_lock_pkg;

  typedef enum logic [3:0] {
    OP_LD_B  = 4'h0,
    OP_LD_W  = 4'h1,
    OP_LD_L  = 4'h2,
    OP_LD_Q  = 4'h3,
    OP_LL_L  = 4'h4,
    OP_LL_Q  = 4'h5,
    OP_LD_QU = 4'h6,
    OP_ST_B  = 4'h8,
    OP_ST_W  = 4'h9,
    OP_ST_L  = 4'hA,
    OP_ST_Q  = 4'hB,
    OP_SC_L  = 4'hC,
    OP_SC_Q  = 4'hD,
    OP_ST_QU = 4'hE
  } memOp_e;

  // size/placement info the datapath needs from decode
  typedef struct packed {
    logic [1:0] sizeLog2;
    logic       forceAlign;
  } accShape_t;

  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic doWrite;
    logic fault;
    logic scReport;
    logic oldLock;
    logic armLock;
  } accStrobe_t;

endpackage

// File: rtl/mem_lock_ctrl.sv
module mem_lock_ctrl
  import mem_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       misaligned,
  input  logic       lockHit,
  output accShape_t  shape,
  output accStrobe_t strobe
);

  logic legal, isStore, isLocked, isCond;
  logic lockFlag;
  logic active, okAccess;

  always_comb begin
    legal    = 1'b1;
    isLocked = 1'b0;
    isCond   = 1'b0;
    shape    = '0;
    isStore  = opCode[3];
    case (opCode)
      OP_LD_B, OP_ST_B:   shape.sizeLog2 = 2'd0;
      OP_LD_W, OP_ST_W:   shape.sizeLog2 = 2'd1;
      OP_LD_L, OP_ST_L:   shape.sizeLog2 = 2'd2;
      OP_LD_Q, OP_ST_Q:   shape.sizeLog2 = 2'd3;
      OP_LL_L: begin shape.sizeLog2 = 2'd2; isLocked = 1'b1; end
      OP_LL_Q: begin shape.sizeLog2 = 2'd3; isLocked = 1'b1; end
      OP_SC_L: begin shape.sizeLog2 = 2'd2; isCond = 1'b1; end
      OP_SC_Q: begin shape.sizeLog2 = 2'd3; isCond = 1'b1; end
      OP_LD_QU, OP_ST_QU: begin
        shape.sizeLog2   = 2'd3;
        shape.forceAlign = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

  assign active   = opValid && legal;
  assign okAccess = active && !misaligned;

  always_comb begin
    strobe          = '0;
    strobe.fault    = active && misaligned;
    strobe.fire     = okAccess && (!isCond || lockFlag);
    strobe.doWrite  = okAccess && (!isCond || lockFlag) && isStore;
    strobe.scReport = okAccess && isCond;
    strobe.oldLock  = lockFlag;
    strobe.armLock  = okAccess && isLocked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockFlag <= 1'b0;
    end else if (okAccess) begin
      if (isLocked)               lockFlag <= 1'b1;
      else if (isCond)            lockFlag <= 1'b0;
      else if (isStore && lockHit) lockFlag <= 1'b0;
    end
  end

  // R5: a successful load-locked leaves the flag set
  a_r5_arm_sets_lock: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armLock |=> lockFlag);

  // R6: a conditional store always leaves the flag clear
  a_r6_sc_clears_lock: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scReport |=> !lockFlag);

  // R8: a faulting access does not move the flag
  a_r8_fault_keeps_lock: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> (lockFlag == $past(lockFlag)));

endmodule

// File: rtl/mem_lock_dp.sv
module mem_lock_dp
  import mem_lock_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] storeData,
  input  accShape_t         shape,
  input  accStrobe_t        strobe,
  output logic              misaligned,
  output logic              lockHit,
  output logic              memReq,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0] memWData,
  output logic              alignFault,
  output logic              scResultValid,
  output logic [DATA_W-1:0] scResult
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] effAddr, quadAddr, lockAddr, laneData;
  logic [OFF_W-1:0]  byteOff, laneOff;
  logic [OFF_W:0]    spanBytes, lowMask;
  logic [LANES-1:0]  laneEn;

  assign effAddr   = baseVal + {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign byteOff   = effAddr[OFF_W-1:0];
  assign quadAddr  = {effAddr[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign spanBytes = (OFF_W+1)'(1) << shape.sizeLog2;
  assign lowMask   = spanBytes - (OFF_W+1)'(1);
  assign misaligned = !shape.forceAlign && (|(byteOff & lowMask[OFF_W-1:0]));
  assign laneOff   = shape.forceAlign ? '0 : byteOff;
  assign lockHit   = (quadAddr == lockAddr);
  assign laneData  = storeData << {laneOff, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneEn[g] = ({1'b0, laneOff} <= (OFF_W+1)'(g)) &&
                       ((OFF_W+1)'(g) < ({1'b0, laneOff} + spanBytes));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReq        <= 1'b0;
      memWrite      <= 1'b0;
      memAddr       <= '0;
      memByteEn     <= '0;
      memWData      <= '0;
      alignFault    <= 1'b0;
      scResultValid <= 1'b0;
      scResult      <= '0;
      lockAddr      <= '0;
    end else begin
      memReq        <= strobe.fire;
      memWrite      <= strobe.doWrite;
      memAddr       <= strobe.fire ? quadAddr : '0;
      memByteEn     <= strobe.fire ? laneEn : '0;
      memWData      <= strobe.doWrite ? laneData : '0;
      alignFault    <= strobe.fault;
      scResultValid <= strobe.scReport;
      scResult      <= strobe.scReport ? DATA_W'(strobe.oldLock) : '0;
      if (strobe.armLock) lockAddr <= quadAddr;
    end
  end

  // R2: a fault pulse never comes with a request or a result
  a_r2_fault_excludes_req: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!memReq && !memWrite && !scResultValid));

  // R1: request addresses are quadword aligned
  a_r1_quad_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0));

  // R3: lane count matches a legal access size
  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
                $countones(memByteEn) == 4 || $countones(memByteEn) == 8));

  // R6: the returned flag occupies bit 0 only
  a_r6_result_bit: assert property (@(posedge clk) disable iff (!rstN)
    scResultValid |-> (scResult[DATA_W-1:1] == '0));

endmodule

// File: rtl/mem_lock_unit.sv
module mem_lock_unit
  import mem_lock_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] storeData,
  output logic              memReq,
  output logic              memWrite,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0] memWData,
  output logic              alignFault,
  output logic              scResultValid,
  output logic [DATA_W-1:0] scResult
);

  accShape_t  shape;
  accStrobe_t strobe;
  logic       misaligned, lockHit;

  mem_lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .misaligned(misaligned), .lockHit(lockHit),
    .shape(shape), .strobe(strobe)
  );

  mem_lock_dp #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_dp (
    .clk(clk), .rstN(rstN), .baseVal(baseVal), .disp(disp),
    .storeData(storeData), .shape(shape), .strobe(strobe),
    .misaligned(misaligned), .lockHit(lockHit),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWData(memWData), .alignFault(alignFault),
    .scResultValid(scResultValid), .scResult(scResult)
  );

  // R9: an idle cycle produces no activity on the next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!memReq && !alignFault && !scResultValid));

endmodule

// File: tb/mem_lock_unit_tb.sv
module mem_lock_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [63:0] baseVal = '0;
  logic [15:0] disp = '0;
  logic [63:0] storeData = '0;
  logic        memReq, memWrite, alignFault, scResultValid;
  logic [63:0] memAddr, memWData, scResult;
  logic [7:0]  memByteEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic        mLock = 1'b0;
  logic [63:0] mLockAddr = '0;

  always #2 clk = ~clk;

  mem_lock_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .baseVal(baseVal), .disp(disp), .storeData(storeData),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWData(memWData), .alignFault(alignFault),
    .scResultValid(scResultValid), .scResult(scResult)
  );

  task automatic checkVal(input string tag, input string field,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, field, act, exp);
    end
  endtask

  task automatic runOp(input logic v, input logic [3:0] op, input logic [63:0] b,
                       input logic [15:0] d, input logic [63:0] sd, input string tag);
    logic [63:0] ea, quad, eAddr, eData, eRes;
    logic [2:0]  lo, off;
    int          sz, n;
    logic        legal, st, fu, mis, lockedOp, condOp, act, ok;
    logic        eReq, eWr, eFault, eScV;
    logic [7:0]  eEn;
    legal = (op != 4'd7) && (op != 4'd15);
    st = op[3];
    lo = op[2:0];
    case (lo)
      3'd0: sz = 0;
      3'd1: sz = 1;
      3'd2, 3'd4: sz = 2;
      default: sz = 3;
    endcase
    n = 1 << sz;
    ea = b + {{48{d[15]}}, d};
    quad = {ea[63:3], 3'b000};
    fu = (lo == 3'd6);
    off = fu ? 3'd0 : ea[2:0];
    mis = !fu && ((int'(ea[2:0]) % n) != 0);
    lockedOp = !st && (lo == 3'd4 || lo == 3'd5);
    condOp = st && (lo == 3'd4 || lo == 3'd5);
    act = v && legal;
    ok = act && !mis;
    eFault = act && mis;
    eReq = ok && (!condOp || mLock);
    eWr = eReq && st;
    eAddr = eReq ? quad : 64'd0;
    eEn = eReq ? (8'((16'd1 << n) - 16'd1) << off) : 8'd0;
    eData = eWr ? (sd << (8 * int'(off))) : 64'd0;
    eScV = ok && condOp;
    eRes = eScV ? {63'd0, mLock} : 64'd0;
    if (ok && lockedOp) begin
      mLock = 1'b1;
      mLockAddr = quad;
    end else if (ok && condOp) begin
      mLock = 1'b0;
    end else if (ok && st && quad == mLockAddr) begin
      mLock = 1'b0;
    end
    @(negedge clk);
    opValid = v; opCode = op; baseVal = b; disp = d; storeData = sd;
    @(posedge clk);
    #1;
    checkVal(tag, "memReq", {63'd0, memReq}, {63'd0, eReq});
    checkVal(tag, "memWrite", {63'd0, memWrite}, {63'd0, eWr});
    checkVal(tag, "memAddr", memAddr, eAddr);
    checkVal(tag, "memByteEn", {56'd0, memByteEn}, {56'd0, eEn});
    checkVal(tag, "memWData", memWData, eData);
    checkVal(tag, "alignFault", {63'd0, alignFault}, {63'd0, eFault});
    checkVal(tag, "scResultValid", {63'd0, scResultValid}, {63'd0, eScV});
    checkVal(tag, "scResult", scResult, eRes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] lk;
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs are zero while reset is held
    checkVal("R10", "memReq", {63'd0, memReq}, 64'd0);
    checkVal("R10", "memAddr", memAddr, 64'd0);
    checkVal("R10", "memByteEn", {56'd0, memByteEn}, 64'd0);
    checkVal("R10", "alignFault", {63'd0, alignFault}, 64'd0);
    checkVal("R10", "scResultValid", {63'd0, scResultValid}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: flag clear out of reset, so a conditional store fails
    runOp(1, 4'hD, 64'h2000, 16'h0, 64'h1111, "R10");

    // R9: idle cycle and unused codes
    runOp(0, 4'hB, 64'h2000, 16'h0, 64'hAAAA, "R9");
    runOp(1, 4'h7, 64'h2000, 16'h0, 64'hAAAA, "R9");
    runOp(1, 4'hF, 64'h2000, 16'h0, 64'hAAAA, "R9");

    // R1: negative displacement wrapping below zero, positive limit
    runOp(1, 4'h3, 64'h0, 16'hFFF8, 64'h0, "R1");
    runOp(1, 4'h2, 64'h1000, 16'h7FFC, 64'h0, "R1");

    // R3: lane placement for byte, word, longword stores
    runOp(1, 4'h8, 64'h3005, 16'h0, 64'h0123_4567_89AB_CDEF, "R3");
    runOp(1, 4'h9, 64'h3000, 16'h6, 64'h0123_4567_89AB_CDEF, "R3");
    runOp(1, 4'hA, 64'h3004, 16'h0, 64'h0123_4567_89AB_CDEF, "R3");

    // R2: misaligned word, longword, quadword
    runOp(1, 4'h1, 64'h3003, 16'h0, 64'h0, "R2");
    runOp(1, 4'hA, 64'h3002, 16'h0, 64'h55, "R2");
    runOp(1, 4'hB, 64'h3004, 16'h0, 64'h55, "R2");

    // R4: unaligned quadword at odd offsets
    runOp(1, 4'hE, 64'h3005, 16'h0, 64'hFEED_FACE_CAFE_BEEF, "R4");
    runOp(1, 4'h6, 64'h3000, 16'h3, 64'h0, "R4");

    // R5 and R6: reserve, succeed once, then fail
    lk = 64'h5000;
    runOp(1, 4'h5, lk, 16'h0, 64'h0, "R5");
    runOp(1, 4'hD, lk, 16'h0, 64'h77, "R6");
    runOp(1, 4'hD, lk, 16'h0, 64'h78, "R6");

    // R7: store into the reserved quadword breaks the reservation
    runOp(1, 4'h4, lk, 16'h0, 64'h0, "R7");
    runOp(1, 4'h8, lk, 16'h3, 64'h9, "R7");
    runOp(1, 4'hC, lk, 16'h0, 64'h5, "R7");
    // R7: store to a neighbouring quadword keeps it
    runOp(1, 4'h5, lk, 16'h0, 64'h0, "R7");
    runOp(1, 4'hB, lk, 16'h8, 64'h9, "R7");
    runOp(1, 4'hD, lk, 16'h0, 64'h6, "R7");

    // R8: faulting conditional store leaves the reservation
    runOp(1, 4'h5, lk, 16'h0, 64'h0, "R8");
    runOp(1, 4'hD, lk, 16'h4, 64'h1, "R8");
    runOp(1, 4'hD, lk, 16'h0, 64'h2, "R8");
    // R8: faulting load-locked does not arm
    runOp(1, 4'h4, lk, 16'h2, 64'h0, "R8");
    runOp(1, 4'hC, lk, 16'h0, 64'h3, "R8");

    // mixed random traffic around a small window so reservations hit often
    void'($urandom(32'd20250611));
    for (int i = 0; i < 600; i++) begin
      logic [63:0] b, sd;
      logic [15:0] d;
      logic [3:0]  op;
      op = 4'($urandom);
      sd = {$urandom, $urandom};
      if ($urandom % 3 == 0) begin
        b = {$urandom, $urandom};
        d = 16'($urandom);
      end else begin
        b = 64'h6000 + 64'($urandom % 48);
        d = 16'($urandom % 16);
      end
      runOp(($urandom % 8) != 0, op, b, d, sd, "R1/R3");
    end

    @(negedge clk);
    opValid = 1'b0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule